// File: doc/BRIEF.md
# PCI Base Address Register Bank with Type Classification

This block keeps a small bank of PCI base address registers for one function. Each slot's read-only mask word is a parameter. After reset the block walks through the slots, one per clock, and works out the type of each slot from its mask. It stores that type per slot, so no later access decodes the mask again. Configuration writes and reads then use the stored type. Firmware sizing needs no special handling: writing all ones goes through the ordinary write path, and the readback returns the size mask together with the fixed type bits.

A 64-bit memory BAR takes two neighbouring slots. The upper slot holds address bits 63:32. The block also tracks the decoded base of slot 0, which is the stored value with bits 3:0 cleared. When a write moves that base, the block raises a one-cycle change pulse, so the surrounding logic can move its address decoder.

The control state machine has two states. `ST_SCAN` is entered on reset and classifies the slot chosen by the scan counter on each clock. The transition `scan_done` leaves `ST_SCAN` for `ST_RUN` when the last slot has been classified. `ST_RUN` accepts configuration writes, and only a reset leaves it.

Top module: `pci_bar_bank`

## Requirements
- R1: During reset, `ready`, `base_addr`, `base_chg` and every `rd_data` are 0. `ready` rises exactly NUM_BARS clock edges after reset is released. Writes made while `ready` is low change nothing.
- R2: Bit 0 of a mask marks an I/O slot. For a memory slot, mask bits 2:1 select the kind: 00 is 32-bit, 01 is below 1 MiB, 10 is 64-bit. A memory slot reads back as (write data AND mask) with bits 3:0 replaced by the type bits. Bits 2:1 carry the kind, and bit 3 is copied from the mask.
- R3: Writing 0xFFFFFFFF to any slot in use reads back as the slot's mask word.
- R4: An I/O slot always reads bit 0 as 1 and bit 1 as 0. Its other bits are the write data AND the mask. A mask with bits 31:16 all zero gives a 16-bit I/O slot.
- R5: A below-1 MiB memory slot (type bits 2:1 = 01) stores no address bit above bit 19, even where the mask has those bits set.
- R6: A 64-bit memory slot reads type bits 3:0 from the mask, with bits 2:1 = 10. The next slot holds the upper 32 bits: it reads back as write data AND its mask and carries no type bits.
- R7: A slot whose mask is zero reads 0 whatever is written to it. A 64-bit kind in the last slot is treated as unused, because it has no partner slot.
- R8: A write to slot 0 sets `base_addr` to the new slot-0 value with bits 3:0 cleared, visible one cycle later. `base_chg` is high in that cycle only if the new value differs from the previous `base_addr`, and it is low again in the next cycle unless another such write follows.
- R9: Writes to any slot other than 0 leave `base_addr` unchanged and never raise `base_chg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_idx | input | IDX_W | Slot selected for the write |
| wr_data | input | 32 | Write data |
| rd_idx | input | IDX_W | Slot selected for the combinational read |
| rd_data | output | 32 | Read value of the selected slot |
| ready | output | 1 | High once all slots have been classified |
| base_addr | output | 32 | Decoded base of slot 0 |
| base_chg | output | 1 | One-cycle pulse when the slot-0 base moves |

## Verification
Every slot kind gets two write patterns: all ones, which is the sizing case, and a mixed value with bits both inside and outside the mask. Comparing the two readbacks separates the write mask from the read-only type bits. The below-1 MiB slot has a mask with high bits set, so the readback shows whether the 20-bit limit is enforced. The unused slot and the unpaired 64-bit slot read zero after all-ones writes. The base tracker is driven with repeated, changed and foreign-slot writes, which separates a real base move from a write that leaves the base where it was.

// File: rtl/bar_pkg.sv
`timescale 1ns/1ps
package bar_pkg;

    typedef enum logic [2:0] {
        BK_NONE, BK_IO16, BK_IO32, BK_MEM20, BK_MEM32, BK_MEM64L, BK_MEM64H
    } bar_kind_t;

    // Bits of the slot value that a write may set.
    function automatic logic [31:0] kind_wmask(bar_kind_t k, logic [31:0] m);
        logic [31:0] r;
        unique case (k)
            BK_NONE:   r = 32'h0;
            BK_IO16:   r = m & 32'h0000_FFFC;
            BK_IO32:   r = m & 32'hFFFF_FFFC;
            BK_MEM20:  r = m & 32'h000F_FFF0;
            BK_MEM32,
            BK_MEM64L: r = m & 32'hFFFF_FFF0;
            BK_MEM64H: r = m;
            default:   r = 32'h0;
        endcase
        return r;
    endfunction

    // Read-only type bits merged into every read.
    function automatic logic [31:0] kind_tbits(bar_kind_t k, logic [31:0] m);
        logic [31:0] r;
        unique case (k)
            BK_IO16, BK_IO32: r = 32'h1;
            BK_MEM20:         r = {28'h0, m[3], 3'b010};
            BK_MEM32:         r = {28'h0, m[3], 3'b000};
            BK_MEM64L:        r = {28'h0, m[3], 3'b100};
            default:          r = 32'h0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bar_classifier.sv
`timescale 1ns/1ps
module bar_classifier
    import bar_pkg::*;
#(
    parameter logic [31:0] MASK = 32'h0,
    parameter bit          LAST = 1'b0
) (
    input  logic      prev_lo,
    output bar_kind_t kind
);
    always_comb begin
        if (prev_lo)
            kind = BK_MEM64H;
        else if (MASK == 32'h0)
            kind = BK_NONE;
        else if (MASK[0])
            kind = (MASK[31:16] == 16'h0) ? BK_IO16 : BK_IO32;
        else begin
            unique case (MASK[2:1])
                2'b00:   kind = BK_MEM32;
                2'b01:   kind = BK_MEM20;
                2'b10:   kind = LAST ? BK_NONE : BK_MEM64L;
                default: kind = BK_NONE;
            endcase
        end
    end
endmodule

// File: rtl/bar_slot.sv
`timescale 1ns/1ps
module bar_slot
    import bar_pkg::*;
#(
    parameter logic [31:0] MASK = 32'h0,
    parameter bit          LAST = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cls_en,
    input  logic        prev_lo,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output bar_kind_t   kind,
    output logic [31:0] wr_view,
    output logic [31:0] rd_word
);
    bar_kind_t   cls_kind;
    logic [31:0] val;

    bar_classifier #(.MASK(MASK), .LAST(LAST)) u_cls (
        .prev_lo (prev_lo),
        .kind    (cls_kind)
    );

    assign wr_view = wr_data & kind_wmask(kind, MASK);
    assign rd_word = val | kind_tbits(kind, MASK);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind <= BK_NONE;
            val  <= 32'h0;
        end else begin
            if (cls_en) kind <= cls_kind;
            if (wr_en)  val  <= wr_view;
        end
    end

    // R7: an unused slot never holds a value
    p_unused_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == BK_NONE) |-> (val == 32'h0));
endmodule

// File: rtl/bar_base_track.sv
`timescale 1ns/1ps
module bar_base_track (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        upd,
    input  logic [31:0] new_word,
    output logic [31:0] base_addr,
    output logic        base_chg
);
    logic [31:0] new_base;
    assign new_base = {new_word[31:4], 4'h0};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= 32'h0;
            base_chg  <= 1'b0;
        end else begin
            base_chg <= upd && (new_base != base_addr);
            if (upd) base_addr <= new_base;
        end
    end

    // R8: the base only moves on a slot-0 update
    p_base_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(base_addr));
    // R8: a pulse always accompanies a different base
    p_chg_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
        base_chg |-> (base_addr != $past(base_addr)));
endmodule

// File: rtl/pci_bar_bank.sv
`timescale 1ns/1ps
module pci_bar_bank
    import bar_pkg::*;
#(
    parameter int NUM_BARS = 8,
    parameter logic [NUM_BARS-1:0][31:0] BAR_MASKS = {
        32'hFFFF_FFF4, 32'h0000_0000, 32'hFFFF_F002, 32'hFFFF_FFFF,
        32'hFFFF_000C, 32'h0000_FFF1, 32'hFFFF_FF01, 32'hFFF8_0000},
    localparam int IDX_W = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data,
    output logic             ready,
    output logic [31:0]      base_addr,
    output logic             base_chg
);
    localparam int SLOTS = 2 ** IDX_W;

    typedef enum logic {ST_SCAN, ST_RUN} bank_state_t;

    bank_state_t      state;
    logic [IDX_W-1:0] scan_idx;
    bar_kind_t        kinds   [NUM_BARS];
    logic [31:0]      views   [NUM_BARS];
    logic [31:0]      words   [SLOTS];
    logic             wr_ok;

    // state register and scan counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_SCAN;
            scan_idx <= '0;
        end else begin
            unique case (state)
                ST_SCAN: begin
                    if (scan_idx == IDX_W'(NUM_BARS - 1))
                        state <= ST_RUN;     // scan_done
                    else
                        scan_idx <= scan_idx + 1'b1;
                end
                ST_RUN: state <= ST_RUN;
            endcase
        end
    end

    // outputs of the state machine
    always_comb begin
        unique case (state)
            ST_SCAN: ready = 1'b0;
            ST_RUN:  ready = 1'b1;
        endcase
    end

    assign wr_ok = wr_en && ready;

    for (genvar i = 0; i < NUM_BARS; i++) begin : g_slot
        logic prev_lo;
        if (i == 0) begin : g_first
            assign prev_lo = 1'b0;
        end else begin : g_next
            assign prev_lo = (kinds[i-1] == BK_MEM64L);
        end
        bar_slot #(.MASK(BAR_MASKS[i]), .LAST(i == NUM_BARS - 1)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .cls_en  (state == ST_SCAN && scan_idx == IDX_W'(i)),
            .prev_lo (prev_lo),
            .wr_en   (wr_ok && wr_idx == IDX_W'(i)),
            .wr_data (wr_data),
            .kind    (kinds[i]),
            .wr_view (views[i]),
            .rd_word (words[i])
        );
    end
    for (genvar j = NUM_BARS; j < SLOTS; j++) begin : g_pad
        assign words[j] = 32'h0;
    end

    assign rd_data = words[rd_idx];

    bar_base_track u_base (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (wr_ok && wr_idx == '0),
        .new_word  (views[0]),
        .base_addr (base_addr),
        .base_chg  (base_chg)
    );

    // R1: once ready, stays ready until reset
    p_ready_stays_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
    // R1: the scan counter never passes the last slot
    p_scan_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN) |-> (32'(scan_idx) < NUM_BARS));
    // R9: a change pulse needs an accepted slot-0 write one cycle earlier
    p_chg_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        base_chg |-> $past(wr_en && ready && wr_idx == '0));
    // R1: nothing reaches the base before classification ends
    p_idle_base_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(base_addr));
endmodule

// File: tb/pci_bar_bank_test.sv
`timescale 1ns/1ps
module pci_bar_bank_test;
    localparam int N = 8;
    localparam int IW = 3;

    typedef struct packed {
        logic [IW-1:0] idx;
        logic [31:0]   wd;
        logic [31:0]   exp;
        logic [23:0]   tag;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 32'hFFFF_FFFF, 32'hFFF8_0000, "R3"},
        '{3'd0, 32'h1234_5678, 32'h1230_0000, "R2"},
        '{3'd1, 32'hFFFF_FFFF, 32'hFFFF_FF01, "R3"},
        '{3'd1, 32'h0000_ABCD, 32'h0000_AB01, "R4"},
        '{3'd2, 32'hFFFF_FFFF, 32'h0000_FFF1, "R4"},
        '{3'd2, 32'h1234_5678, 32'h0000_5671, "R4"},
        '{3'd3, 32'hFFFF_FFFF, 32'hFFFF_000C, "R3"},
        '{3'd3, 32'h89AB_CDEF, 32'h89AB_000C, "R6"},
        '{3'd4, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R6"},
        '{3'd4, 32'h0000_0000, 32'h0000_0000, "R6"},
        '{3'd5, 32'hFFFF_FFFF, 32'h000F_F002, "R5"},
        '{3'd5, 32'h0001_2345, 32'h0001_2002, "R5"},
        '{3'd6, 32'hFFFF_FFFF, 32'h0000_0000, "R7"},
        '{3'd7, 32'hFFFF_FFFF, 32'h0000_0000, "R7"}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [31:0]   wr_data = '0;
    logic [IW-1:0] rd_idx = '0;
    logic [31:0]   rd_data;
    logic          ready;
    logic [31:0]   base_addr;
    logic          base_chg;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pci_bar_bank uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .ready(ready), .base_addr(base_addr), .base_chg(base_chg)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [IW-1:0] idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [IW-1:0] idx, input logic [31:0] exp);
        rd_idx = idx;
        #0.5;
        check(req, rd_data, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {31'h0, ready}, 32'h0);
        check("R1", base_addr, 32'h0);
        check("R1", {31'h0, base_chg}, 32'h0);
        read_chk("R1", 3'd3, 32'h0);
        // release reset and write slot 0 during the scan
        rst_n = 1'b1;
        wr_en = 1'b1; wr_idx = 3'd0; wr_data = 32'hFFFF_FFFF;
        for (int k = 1; k <= N; k++) begin
            @(negedge clk);
            if (k == N - 1) check("R1", {31'h0, ready}, 32'h0);
            if (k == N)     check("R1", {31'h0, ready}, 32'h1);
        end
        wr_en = 1'b0;
        read_chk("R1", 3'd0, 32'h0);
        check("R1", base_addr, 32'h0);

        // vector table walk
        for (int v = 0; v < NV; v++) begin
            do_write(VECS[v].idx, VECS[v].wd);
            read_chk(string'(VECS[v].tag), VECS[v].idx, VECS[v].exp);
        end
        // R6: upper slot write did not disturb the lower slot
        read_chk("R6", 3'd3, 32'h89AB_000C);

        // R8: base moves from 0x12300000 to the size mask
        do_write(3'd0, 32'hFFFF_FFFF);
        check("R8", base_addr, 32'hFFF8_0000);
        check("R8", {31'h0, base_chg}, 32'h1);
        @(negedge clk);
        check("R8", {31'h0, base_chg}, 32'h0);
        // R8: same value again, no pulse
        do_write(3'd0, 32'hFFFF_FFFF);
        check("R8", {31'h0, base_chg}, 32'h0);
        check("R8", base_addr, 32'hFFF8_0000);
        // R9: other slot, base untouched
        do_write(3'd3, 32'h0000_0000);
        check("R9", {31'h0, base_chg}, 32'h0);
        check("R9", base_addr, 32'hFFF8_0000);
        do_write(3'd1, 32'h1111_1111);
        check("R9", {31'h0, base_chg}, 32'h0);
        // R8: new base with low bits written
        do_write(3'd0, 32'h0008_000F);
        check("R8", base_addr, 32'h0008_0000);
        check("R8", {31'h0, base_chg}, 32'h1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule